// File: doc/BRIEF.md
# Branch Condition and Stack Unit

This unit decides program flow for an 8-bit processor core that has a 16-bit program counter and a 16-bit stack pointer. It is given one already-fetched control-transfer instruction at a time, as an operation code with its operand bytes. The operations are absolute jumps, relative jumps, counted-loop branches, subroutine calls, returns, and register-pair push and pop. The unit tests a 3-bit condition against the processor flags. It works out the next program counter, stack pointer and loop counter. Whenever a stack transfer is needed, it moves the bytes through a byte-wide request/acknowledge memory port.

A caller raises `start_i` for one cycle while the unit is idle. The unit captures all inputs in that cycle. It then runs zero or two memory transfers. When the results on its outputs are valid, it pulses `done_o`. The results stay unchanged until the next accepted start.

Top module: `flow_unit`

## Requirements
- R1: The full 3-bit condition (`cond_i`) is tested against `flags_i`, where bit 0 is carry, bit 1 is parity, bit 2 is zero and bit 3 is sign. Codes 0..7 mean zero clear, zero set, carry clear, carry set, parity clear, parity set, sign clear and sign set. This full test applies to the conditional jump (op 1), conditional call (op 6) and conditional return (op 8).
- R2: The conditional relative jump (op 3) tests only `cond_i[1:0]`, so it uses the first four conditions of R1. The value of `cond_i[2]` has no effect on it.
- R3: A taken relative jump (op 2, or op 3 with a true condition) sets the PC to `pc_i + 2 + sign-extended disp_i`, wrapping modulo 2^16.
- R4: The counted-loop branch (op 4) sets `b_o` to `b_i - 1` modulo 256. It is taken, with the R3 target, exactly when that new value is not zero.
- R5: An absolute jump (op 0, or op 1 with a true condition) sets the PC to `{imm_hi_i, imm_lo_i}`.
- R6: When an instruction is not taken, the PC becomes `pc_i` plus the instruction length. The lengths are 3 for jump and call, 2 for relative jump and loop, and 1 for return, push, pop and unlisted codes. In that case `taken_o` is 0, `sp_o` equals `sp_i`, and no memory request is made.
- R7: A call (op 5, or op 6 with a true condition) writes `pc_i + 3` to the stack: first the high byte at `sp_i - 1`, then the low byte at `sp_i - 2`. It then sets `sp_o = sp_i - 2` and sets the PC to the immediate word.
- R8: A push (op 9) writes `pair_i` with the same byte order and addresses as R7. It sets `sp_o = sp_i - 2` and the PC to `pc_i + 1`.
- R9: A return (op 7, or op 8 with a true condition) reads the low byte at `sp_i`, then the high byte at `sp_i + 1`. The PC becomes that word and `sp_o = sp_i + 2`.
- R10: A pop (op 10) reads in the same way as R9. `pair_o` becomes the word read, `sp_o = sp_i + 2`, and the PC becomes `pc_i + 1`.
- R11: A request holds its address, direction and write data steady until `mem_ack_i` is seen, and each acknowledge completes one byte. `done_o` is a one-cycle pulse. It comes one cycle after the start when there are no transfers, or one cycle after the last acknowledge. `busy_o` is high from the cycle after the start up to and including the `done_o` cycle. A start while busy is ignored. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Accept an instruction when idle |
| op_i | input | 4 | Operation code (0..10, see requirements) |
| cond_i | input | 3 | Condition selector |
| flags_i | input | 4 | Sign, zero, parity, carry flags |
| pc_i | input | 16 | Address of the instruction |
| sp_i | input | 16 | Current stack pointer |
| b_i | input | 8 | Current loop counter register |
| pair_i | input | 16 | Register pair to push |
| imm_lo_i | input | 8 | Low byte of 16-bit immediate |
| imm_hi_i | input | 8 | High byte of 16-bit immediate |
| disp_i | input | 8 | Signed relative displacement |
| mem_ack_i | input | 1 | Memory byte acknowledge |
| mem_rdata_i | input | 8 | Memory read byte, valid with acknowledge |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| taken_o | output | 1 | Branch, call, return or stack move performed |
| pc_o | output | 16 | Next program counter |
| sp_o | output | 16 | Next stack pointer |
| b_o | output | 8 | Next loop counter register |
| pair_o | output | 16 | Register pair result |
| mem_req_o | output | 1 | Memory byte request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |

## Verification
The hardest case to reach from the ports is a stack transfer held under a slow acknowledge while a second start arrives. This is the only moment when the held address and data could drift, and when the ignored start could corrupt the captured operands. The stimulus runs calls, pushes, returns and pops with acknowledge delays of zero to three cycles. In one call it keeps `start_i` high and changes every operand input while the transfers are still pending. The reference model then expects the byte order, the cycle of the done pulse and the results of the original call only.

// File: rtl/flow_pkg.sv
package flow_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int COND_W = 3;
    localparam int FLAG_W = 4;
    localparam int OP_W   = 4;

    // flag vector bit positions
    localparam int FLG_C = 0;
    localparam int FLG_P = 1;
    localparam int FLG_Z = 2;
    localparam int FLG_S = 3;

    typedef enum logic [OP_W-1:0] {
        OP_JP     = 4'd0,
        OP_JPCC   = 4'd1,
        OP_JR     = 4'd2,
        OP_JRCC   = 4'd3,
        OP_DJNZ   = 4'd4,
        OP_CALL   = 4'd5,
        OP_CALLCC = 4'd6,
        OP_RET    = 4'd7,
        OP_RETCC  = 4'd8,
        OP_PUSH   = 4'd9,
        OP_POP    = 4'd10
    } flow_op_e;

    typedef enum logic [1:0] {
        STK_NONE  = 2'd0,
        STK_WRITE = 2'd1,
        STK_READ  = 2'd2
    } stk_mode_e;

    typedef struct packed {
        logic              taken;
        logic              load_pc;
        logic              load_pair;
        stk_mode_e         mode;
        logic [ADDR_W-1:0] pc_next;
        logic [ADDR_W-1:0] sp_next;
        logic [BYTE_W-1:0] b_next;
        logic [ADDR_W-1:0] pair_next;
        logic [ADDR_W-1:0] wword;
        logic [ADDR_W-1:0] base_addr;
    } plan_t;

    function automatic logic [ADDR_W-1:0] sext_disp(input logic [BYTE_W-1:0] d);
        return {{(ADDR_W-BYTE_W){d[BYTE_W-1]}}, d};
    endfunction

    function automatic logic [ADDR_W-1:0] op_length(input flow_op_e op);
        case (op)
            OP_JP, OP_JPCC, OP_CALL, OP_CALLCC: return ADDR_W'(3);
            OP_JR, OP_JRCC, OP_DJNZ:            return ADDR_W'(2);
            default:                            return ADDR_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
    import flow_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic [FLAG_W-1:0] flags,
    input  logic              short_form,
    output logic              cond_true
);
    localparam int NCOND = 1 << COND_W;

    logic [FLAG_W-1:0] fsel;
    logic [NCOND-1:0]  lut;
    logic [COND_W-1:0] idx;

    // condition pairs: zero, carry, parity, sign; even code = flag clear
    assign fsel = {flags[FLG_S], flags[FLG_P], flags[FLG_C], flags[FLG_Z]};

    for (genvar g = 0; g < NCOND/2; g++) begin : g_pair
        assign lut[2*g]   = ~fsel[g];
        assign lut[2*g+1] =  fsel[g];
    end

    assign idx       = short_form ? {1'b0, cond[COND_W-2:0]} : cond;
    assign cond_true = lut[idx];

endmodule

// File: rtl/flow_plan.sv
module flow_plan
    import flow_pkg::*;
(
    input  flow_op_e          op,
    input  logic              cond_true,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] sp,
    input  logic [BYTE_W-1:0] b,
    input  logic [ADDR_W-1:0] pair,
    input  logic [ADDR_W-1:0] imm,
    input  logic [BYTE_W-1:0] disp,
    output plan_t             plan
);
    logic [ADDR_W-1:0] pc_seq;
    logic [ADDR_W-1:0] pc_rel;
    logic [BYTE_W-1:0] b_dec;

    assign pc_seq = pc + op_length(op);
    assign pc_rel = pc_seq + sext_disp(disp);
    assign b_dec  = b - BYTE_W'(1);

    always_comb begin
        plan           = '0;
        plan.mode      = STK_NONE;
        plan.pc_next   = pc_seq;
        plan.sp_next   = sp;
        plan.b_next    = b;
        plan.pair_next = pair;
        plan.base_addr = sp;
        case (op)
            OP_JP: begin
                plan.taken   = 1'b1;
                plan.pc_next = imm;
            end
            OP_JPCC: begin
                plan.taken = cond_true;
                if (cond_true) plan.pc_next = imm;
            end
            OP_JR: begin
                plan.taken   = 1'b1;
                plan.pc_next = pc_rel;
            end
            OP_JRCC: begin
                plan.taken = cond_true;
                if (cond_true) plan.pc_next = pc_rel;
            end
            OP_DJNZ: begin
                plan.b_next = b_dec;
                plan.taken  = (b_dec != '0);
                if (b_dec != '0) plan.pc_next = pc_rel;
            end
            OP_CALL, OP_CALLCC: begin
                if (op == OP_CALL || cond_true) begin
                    plan.taken     = 1'b1;
                    plan.mode      = STK_WRITE;
                    plan.wword     = pc_seq;
                    plan.base_addr = sp - ADDR_W'(1);
                    plan.sp_next   = sp - ADDR_W'(2);
                    plan.pc_next   = imm;
                end
            end
            OP_RET, OP_RETCC: begin
                if (op == OP_RET || cond_true) begin
                    plan.taken   = 1'b1;
                    plan.mode    = STK_READ;
                    plan.load_pc = 1'b1;
                    plan.sp_next = sp + ADDR_W'(2);
                end
            end
            OP_PUSH: begin
                plan.taken     = 1'b1;
                plan.mode      = STK_WRITE;
                plan.wword     = pair;
                plan.base_addr = sp - ADDR_W'(1);
                plan.sp_next   = sp - ADDR_W'(2);
            end
            OP_POP: begin
                plan.taken     = 1'b1;
                plan.mode      = STK_READ;
                plan.load_pair = 1'b1;
                plan.sp_next   = sp + ADDR_W'(2);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/flow_stack_seq.sv
module flow_stack_seq
    import flow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  plan_t             plan_in,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output plan_t             plan_q,
    output logic [ADDR_W-1:0] rd_word
);
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XF0  = 2'd1,
        ST_XF1  = 2'd2,
        ST_FIN  = 2'd3
    } seq_state_e;

    seq_state_e state;
    logic       accept;
    logic       is_write;
    logic       in_xfer;

    assign accept   = start && (state == ST_IDLE);
    assign is_write = (plan_q.mode == STK_WRITE);
    assign in_xfer  = (state == ST_XF0) || (state == ST_XF1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            plan_q  <= '0;
            rd_word <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        plan_q  <= plan_in;
                        rd_word <= '0;
                        state   <= (plan_in.mode == STK_NONE) ? ST_FIN : ST_XF0;
                    end
                end
                ST_XF0: begin
                    if (mem_ack) begin
                        if (!is_write) rd_word[BYTE_W-1:0] <= mem_rdata;
                        state <= ST_XF1;
                    end
                end
                ST_XF1: begin
                    if (mem_ack) begin
                        if (!is_write) rd_word[ADDR_W-1:BYTE_W] <= mem_rdata;
                        state <= ST_FIN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // writes go downward (high byte first), reads go upward (low byte first)
    always_comb begin
        mem_req   = in_xfer;
        mem_we    = in_xfer && is_write;
        mem_addr  = plan_q.base_addr;
        mem_wdata = '0;
        if (state == ST_XF1) begin
            mem_addr = is_write ? plan_q.base_addr - ADDR_W'(1)
                                : plan_q.base_addr + ADDR_W'(1);
        end
        if (is_write) begin
            mem_wdata = (state == ST_XF1) ? plan_q.wword[BYTE_W-1:0]
                                          : plan_q.wword[ADDR_W-1:BYTE_W];
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_FIN);

endmodule

// File: rtl/flow_unit.sv
module flow_unit
    import flow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [COND_W-1:0] cond_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [BYTE_W-1:0] b_i,
    input  logic [ADDR_W-1:0] pair_i,
    input  logic [BYTE_W-1:0] imm_lo_i,
    input  logic [BYTE_W-1:0] imm_hi_i,
    input  logic [BYTE_W-1:0] disp_i,
    input  logic              mem_ack_i,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic [BYTE_W-1:0] b_o,
    output logic [ADDR_W-1:0] pair_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o
);
    flow_op_e          op;
    logic              cond_true;
    plan_t             plan_c;
    plan_t             plan_q;
    logic [ADDR_W-1:0] rd_word;

    assign op = flow_op_e'(op_i);

    flow_cond_eval u_cond (
        .cond       (cond_i),
        .flags      (flags_i),
        .short_form (op == OP_JRCC),
        .cond_true  (cond_true)
    );

    flow_plan u_plan (
        .op        (op),
        .cond_true (cond_true),
        .pc        (pc_i),
        .sp        (sp_i),
        .b         (b_i),
        .pair      (pair_i),
        .imm       ({imm_hi_i, imm_lo_i}),
        .disp      (disp_i),
        .plan      (plan_c)
    );

    flow_stack_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .plan_in   (plan_c),
        .mem_ack   (mem_ack_i),
        .mem_rdata (mem_rdata_i),
        .mem_req   (mem_req_o),
        .mem_we    (mem_we_o),
        .mem_addr  (mem_addr_o),
        .mem_wdata (mem_wdata_o),
        .busy      (busy_o),
        .done      (done_o),
        .plan_q    (plan_q),
        .rd_word   (rd_word)
    );

    assign taken_o = plan_q.taken;
    assign pc_o    = plan_q.load_pc   ? rd_word : plan_q.pc_next;
    assign pair_o  = plan_q.load_pair ? rd_word : plan_q.pair_next;
    assign sp_o    = plan_q.sp_next;
    assign b_o     = plan_q.b_next;

endmodule

// File: rtl/flow_unit_chk.sv
module flow_unit_chk
    import flow_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [OP_W-1:0]   op_i,
    input logic [ADDR_W-1:0] sp_i,
    input logic [BYTE_W-1:0] b_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              taken_o,
    input logic [ADDR_W-1:0] sp_o,
    input logic [BYTE_W-1:0] b_o,
    input logic              mem_req_o,
    input logic              mem_ack_i,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [BYTE_W-1:0] mem_wdata_o
);
    logic [OP_W-1:0]   op_seen;
    logic [ADDR_W-1:0] sp_seen;
    logic [BYTE_W-1:0] b_seen;
    logic              is_wr_op;
    logic              is_rd_op;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_seen <= '0;
            sp_seen <= '0;
            b_seen  <= '0;
        end else if (start_i && !busy_o) begin
            op_seen <= op_i;
            sp_seen <= sp_i;
            b_seen  <= b_i;
        end
    end

    assign is_wr_op = (op_seen == OP_CALL) || (op_seen == OP_CALLCC) || (op_seen == OP_PUSH);
    assign is_rd_op = (op_seen == OP_RET) || (op_seen == OP_RETCC) || (op_seen == OP_POP);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mem_req_o && !done_o); // R11
    AST_SP_KEPT: assert property (@(posedge clk) disable iff (rst)
        done_o && !taken_o |-> sp_o == sp_seen); // R6
    AST_LOOP_DEC: assert property (@(posedge clk) disable iff (rst)
        done_o && op_seen == OP_DJNZ |-> b_o == BYTE_W'(b_seen - BYTE_W'(1))); // R4
    AST_SP_DOWN: assert property (@(posedge clk) disable iff (rst)
        done_o && taken_o && is_wr_op |-> sp_o == ADDR_W'(sp_seen - ADDR_W'(2))); // R7
    AST_SP_UP: assert property (@(posedge clk) disable iff (rst)
        done_o && taken_o && is_rd_op |-> sp_o == ADDR_W'(sp_seen + ADDR_W'(2))); // R9

endmodule

bind flow_unit flow_unit_chk chk_i (.*);

// File: tb/flow_unit_tb_top.sv
`timescale 1ns/1ps
module flow_unit_tb_top;
    import flow_pkg::*;

    logic        clk, rst, start_i;
    logic [3:0]  op_i;
    logic [2:0]  cond_i;
    logic [3:0]  flags_i;
    logic [15:0] pc_i, sp_i, pair_i;
    logic [7:0]  b_i, imm_lo_i, imm_hi_i, disp_i;
    logic        mem_ack_i;
    logic [7:0]  mem_rdata_i;
    logic        busy_o, done_o, taken_o, mem_req_o, mem_we_o;
    logic [15:0] pc_o, sp_o, pair_o, mem_addr_o;
    logic [7:0]  b_o, mem_wdata_o;

    int total = 0;
    int bad   = 0;
    int lat   = 0;
    int wcnt  = 0;
    int cyc   = 0;

    typedef struct {
        bit          we;
        logic [15:0] addr;
        logic [7:0]  data;
    } xfer_t;
    xfer_t expq[$];
    logic [7:0] mem [int];

    flow_unit dut_i (.*);

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog: actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // memory responder with programmable acknowledge delay
    always @(negedge clk) begin
        mem_ack_i = 1'b0;
        if (!rst && mem_req_o === 1'b1) begin
            if (expq.size() == 0) begin
                chk("R11", "unexpected request", 1, 0);
            end else begin
                chk("R7", "req direction", mem_we_o, expq[0].we);
                chk("R9", "req address", mem_addr_o, expq[0].addr);
                if (expq[0].we) chk("R8", "write byte", mem_wdata_o, expq[0].data);
                if (wcnt == lat) begin
                    mem_ack_i = 1'b1;
                    wcnt = 0;
                    if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
                    else mem_rdata_i = mem.exists(int'(mem_addr_o)) ? mem[int'(mem_addr_o)] : 8'h00;
                    void'(expq.pop_front());
                end else begin
                    wcnt++;
                end
            end
        end
    end

    function automatic bit cond_ok(logic [2:0] c, logic [3:0] f, bit short_f);
        logic [2:0] cc = short_f ? {1'b0, c[1:0]} : c;
        case (cc)
            3'd0: return !f[2];
            3'd1: return f[2];
            3'd2: return !f[0];
            3'd3: return f[0];
            3'd4: return !f[1];
            3'd5: return f[1];
            3'd6: return !f[3];
            default: return f[3];
        endcase
    endfunction

    function automatic logic [7:0] peek(logic [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
    endfunction

    task automatic run_op(input string req, input logic [3:0] op, input logic [2:0] cond,
                          input logic [3:0] flags, input logic [15:0] pc, input logic [15:0] sp,
                          input logic [7:0] b, input logic [15:0] pair, input logic [15:0] imm,
                          input logic [7:0] disp, input bit hammer);
        logic [15:0] e_pc, e_sp, e_pair, nxt;
        logic [7:0]  e_b;
        bit          e_tk;
        int          nb, n;
        e_sp = sp; e_b = b; e_pair = pair; e_tk = 0; nb = 0;
        case (op)
            4'd0, 4'd1: begin
                nxt = pc + 16'd3;
                e_tk = (op == 4'd0) || cond_ok(cond, flags, 0);
                e_pc = e_tk ? imm : nxt;
            end
            4'd2, 4'd3: begin
                nxt = pc + 16'd2;
                e_tk = (op == 4'd2) || cond_ok(cond, flags, 1);
                e_pc = e_tk ? 16'(nxt + {{8{disp[7]}}, disp}) : nxt;
            end
            4'd4: begin
                nxt = pc + 16'd2;
                e_b = b - 8'd1;
                e_tk = (e_b != 0);
                e_pc = e_tk ? 16'(nxt + {{8{disp[7]}}, disp}) : nxt;
            end
            4'd5, 4'd6: begin
                nxt = pc + 16'd3;
                e_tk = (op == 4'd5) || cond_ok(cond, flags, 0);
                e_pc = e_tk ? imm : nxt;
                if (e_tk) begin
                    e_sp = sp - 16'd2; nb = 2;
                    expq.push_back('{1, 16'(sp - 16'd1), nxt[15:8]});
                    expq.push_back('{1, 16'(sp - 16'd2), nxt[7:0]});
                end
            end
            4'd7, 4'd8: begin
                nxt = pc + 16'd1;
                e_tk = (op == 4'd7) || cond_ok(cond, flags, 0);
                e_pc = nxt;
                if (e_tk) begin
                    e_pc = {peek(16'(sp + 16'd1)), peek(sp)};
                    e_sp = sp + 16'd2; nb = 2;
                    expq.push_back('{0, sp, 8'h00});
                    expq.push_back('{0, 16'(sp + 16'd1), 8'h00});
                end
            end
            4'd9: begin
                e_pc = pc + 16'd1; e_tk = 1; e_sp = sp - 16'd2; nb = 2;
                expq.push_back('{1, 16'(sp - 16'd1), pair[15:8]});
                expq.push_back('{1, 16'(sp - 16'd2), pair[7:0]});
            end
            4'd10: begin
                e_pc = pc + 16'd1; e_tk = 1; e_sp = sp + 16'd2; nb = 2;
                e_pair = {peek(16'(sp + 16'd1)), peek(sp)};
                expq.push_back('{0, sp, 8'h00});
                expq.push_back('{0, 16'(sp + 16'd1), 8'h00});
            end
            default: e_pc = pc + 16'd1;
        endcase

        @(negedge clk);
        op_i = op; cond_i = cond; flags_i = flags; pc_i = pc; sp_i = sp; b_i = b;
        pair_i = pair; imm_lo_i = imm[7:0]; imm_hi_i = imm[15:8]; disp_i = disp;
        start_i = 1'b1;
        wcnt = 0;
        @(negedge clk);
        start_i = hammer;
        if (hammer) begin
            op_i = 4'd0; pc_i = ~pc; sp_i = ~sp; b_i = ~b; pair_i = ~pair;
            imm_lo_i = ~imm[7:0]; imm_hi_i = ~imm[15:8]; disp_i = ~disp;
        end
        chk("R11", "busy after start", busy_o, 1);
        n = 1;
        while (!done_o && n < 100) begin
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        chk("R11", {req, " done cycle"}, n, 1 + nb * (lat + 1));
        chk(req, "pc", pc_o, e_pc);
        chk(req, "sp", sp_o, e_sp);
        chk(req, "b", b_o, e_b);
        chk(req, "pair", pair_o, e_pair);
        chk(req, "taken", taken_o, e_tk);
        chk(req, "transfers left", expq.size(), 0);
        @(negedge clk);
        chk("R11", "done pulse single", done_o, 0);
        chk("R11", "idle after done", busy_o, 0);
        chk(req, "pc held", pc_o, e_pc);
        expq.delete();
    endtask

    initial begin
        rst = 1'b1; start_i = 0; op_i = 0; cond_i = 0; flags_i = 0; pc_i = 0; sp_i = 0;
        b_i = 0; pair_i = 0; imm_lo_i = 0; imm_hi_i = 0; disp_i = 0;
        mem_ack_i = 0; mem_rdata_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "reset done", done_o, 0);
        chk("R11", "reset busy", busy_o, 0);
        chk("R11", "reset req", mem_req_o, 0);
        chk("R11", "reset pc", pc_o, 0);
        chk("R11", "reset sp", sp_o, 0);

        // R5 unconditional jump
        run_op("R5", 4'd0, 3'd0, 4'h0, 16'h1234, 16'h8000, 8'h10, 16'h0, 16'hBEEF, 8'h00, 0);
        // R1 every condition against two flag patterns
        for (int c = 0; c < 8; c++) begin
            run_op("R1", 4'd1, 3'(c), 4'b0101, 16'h2000, 16'h8000, 8'h01, 16'h0, 16'hA55A, 8'h00, 0);
            run_op("R1", 4'd1, 3'(c), 4'b1010, 16'h2000, 16'h8000, 8'h01, 16'h0, 16'hA55A, 8'h00, 0);
        end
        // R3 relative jumps with wrap and negative offset
        run_op("R3", 4'd2, 3'd0, 4'h0, 16'hFFF0, 16'h8000, 8'h01, 16'h0, 16'h0, 8'h20, 0);
        run_op("R3", 4'd2, 3'd0, 4'h0, 16'h1000, 16'h8000, 8'h01, 16'h0, 16'h0, 8'h80, 0);
        // R2 short condition: cond[2] must not matter
        for (int c = 0; c < 8; c++) begin
            run_op("R2", 4'd3, 3'(c), 4'b0100, 16'h3000, 16'h8000, 8'h01, 16'h0, 16'h0, 8'hF0, 0);
            run_op("R2", 4'd3, 3'(c), 4'b1011, 16'h3000, 16'h8000, 8'h01, 16'h0, 16'h0, 8'h7F, 0);
        end
        // R4 loop branch: reaching zero, wrapping from zero, ordinary count
        run_op("R4", 4'd4, 3'd0, 4'h0, 16'h4000, 16'h8000, 8'h01, 16'h0, 16'h0, 8'hFC, 0);
        run_op("R4", 4'd4, 3'd0, 4'h0, 16'h4000, 16'h8000, 8'h00, 16'h0, 16'h0, 8'hFC, 0);
        run_op("R4", 4'd4, 3'd0, 4'h0, 16'h4000, 16'h8000, 8'h05, 16'h0, 16'h0, 8'h10, 0);
        // R7 calls at several acknowledge delays, R6 false condition
        for (int l = 0; l < 4; l++) begin
            lat = l;
            run_op("R7", 4'd5, 3'd0, 4'h0, 16'h5000 + 16'(l), 16'h9000, 8'h01, 16'h0, 16'h6000, 8'h00, 0);
        end
        lat = 1;
        run_op("R7", 4'd6, 3'd3, 4'b0001, 16'h5100, 16'h0001, 8'h01, 16'h0, 16'h6100, 8'h00, 0);
        run_op("R6", 4'd6, 3'd3, 4'b0000, 16'h5100, 16'h9000, 8'h01, 16'h0, 16'h6100, 8'h00, 0);
        // R8 push then R10 pop of the same word
        lat = 2;
        run_op("R8", 4'd9, 3'd0, 4'h0, 16'h7000, 16'hA000, 8'h01, 16'hC3D4, 16'h0, 8'h00, 0);
        run_op("R10", 4'd10, 3'd0, 4'h0, 16'h7001, 16'h9FFE, 8'h01, 16'h0000, 16'h0, 8'h00, 0);
        // R9 return pops the address written by an earlier call
        lat = 0;
        run_op("R7", 4'd5, 3'd0, 4'h0, 16'h1230, 16'hB000, 8'h01, 16'h0, 16'h4444, 8'h00, 0);
        run_op("R9", 4'd7, 3'd0, 4'h0, 16'h4444, 16'hAFFE, 8'h01, 16'h0, 16'h0, 8'h00, 0);
        lat = 3;
        run_op("R9", 4'd8, 3'd7, 4'b1000, 16'h4444, 16'hAFFE, 8'h01, 16'h0, 16'h0, 8'h00, 0);
        run_op("R6", 4'd8, 3'd7, 4'b0000, 16'h4444, 16'hAFFE, 8'h01, 16'h0, 16'h0, 8'h00, 0);
        run_op("R6", 4'd13, 3'd0, 4'h0, 16'h0100, 16'hAFFE, 8'h01, 16'h0, 16'h0, 8'h00, 0);
        // R11 start held high with changing operands during a slow call
        lat = 2;
        run_op("R11", 4'd5, 3'd0, 4'h0, 16'h0ABC, 16'hC000, 8'h22, 16'h1111, 16'h7777, 8'h00, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule